// File: doc/BRIEF.md
# Pointer-Addressed Control Register Front End

This block sits between a 16-bit host bus and the configuration state of a serial communication controller. Register 0 is the gateway. A write to it loads a 4-bit pointer and also carries command fields. Those fields become one-clock strobes that the channel logic consumes, for example clearing interrupt conditions, starting an abort sequence or resetting CRC state. The next access goes to whichever register the pointer names. After that access the pointer falls back to 0, so host software always alternates between a pointer/command write and a data access.

The host moves one byte per access. On a write, only the low lane of the bus is used. On a read, the selected byte is placed on the low lane and repeated on the high lane. A mode input selects the alternate bus mode. In that mode register 0 does not load the pointer. Instead, its two lowest bits can latch a shift-direction code that is visible on reads of register 0.

Top module: `ctrl_reg_frontend`

## Requirements
- R1: While `rst_n` is low, the pointer, the shift code (`shift_o`) and all stored registers (`wreg_o`) are cleared. `cmd_stb_o` and `rdata` are 0 when no access is presented.
- R2: An access is a cycle with `cs` high and exactly one of `rd`/`wr` high. In normal mode (`alt_mode`=0), a write at pointer 0 whose bits 5..3 are not 001 loads the pointer with bits 2..0.
- R3: In normal mode, a write at pointer 0 whose bits 5..3 equal 001 loads the pointer with 8 + bits 2..0 and raises no strobe.
- R4: During a write at pointer 0, bits 5..3 raise one bit of `cmd_stb_o` in that same cycle. The mapping is 010→bit0 (clear external/status interrupt), 011→bit1 (abort), 100→bit2 (arm interrupt on next received byte), 101→bit3 (clear transmit interrupt pending), 110→bit4 (clear errors), 111→bit5 (release highest in-service level). Codes 000 and 001 raise nothing.
- R5: During the same write, bits 7..6 raise a second strobe: 01→bit6 (receive CRC reset), 10→bit7 (transmit CRC reset), 11→bit8 (clear transmit underrun/end-of-message latch). Code 00 raises nothing.
- R6: A write at pointer p≠0 stores `wdata[7:0]` into register p. `wdata[15:8]` is ignored.
- R7: A read at pointer p≠0 returns register p on both `rdata[7:0]` and `rdata[15:8]`. Any access at p≠0, read or write, returns the pointer to 0 on the next clock.
- R8: A read at pointer 0 returns {6'b0, shift code} on both lanes. Outside a read, `rdata` is 0.
- R9: In alternate mode, a write at pointer 0 leaves the pointer at 0. Bits 1..0 equal to 10 (left) or 11 (right) latch that code into `shift_o`, and codes 00/01 leave `shift_o` unchanged. R4 and R5 strobes still apply, and code 001 is null.
- R10: A write at pointer 0 changes no stored register. Writes at p≠0 and all reads raise no strobe.
- R11: A cycle with `cs` low, or with `rd` and `wr` both high, is not an access. It changes no state, raises no strobe and drives `rdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| alt_mode | input | 1 | 1 selects the alternate bus mode for register 0 |
| wdata | input | 16 | Write data bus; only the low byte is used |
| rdata | output | 16 | Read data, byte replicated on both lanes |
| cmd_stb_o | output | 9 | One-cycle command strobes |
| shift_o | output | 2 | Latched shift-direction code |
| wreg_o | output | 128 | Stored registers, register n at bits 8n+7..8n |

## Verification
The bench aims at the points where pointer and command fields overlap. A write at pointer 0 whose bits also look like data must steer rather than store. A data byte written at a non-zero pointer must not be decoded as commands, and a design that got this wrong would emit stray strobes. The upper-bank code 001 must reach registers 8-15 without firing any strobe. In the alternate mode a design that kept loading the pointer would return register contents where the shift code is expected. The bench also checks that a deselected access or one with both strobes high leaves the pointer untouched, which shows up as a changed read result afterwards.

// File: rtl/ctrl_fe_pkg.sv
package ctrl_fe_pkg;
  localparam int BYTE_W   = 8;
  localparam int BUS_W    = 2 * BYTE_W;
  localparam int NREG     = 16;
  localparam int PTR_W    = $clog2(NREG);
  localparam int STB_N    = 9;
  localparam int SHIFT_W  = 2;

  // strobe positions
  localparam int STB_EXT_CLR   = 0;
  localparam int STB_ABORT     = 1;
  localparam int STB_RX_ARM    = 2;
  localparam int STB_TXIP_CLR  = 3;
  localparam int STB_ERR_CLR   = 4;
  localparam int STB_IUS_CLR   = 5;
  localparam int STB_RXCRC_RST = 6;
  localparam int STB_TXCRC_RST = 7;
  localparam int STB_UNDR_CLR  = 8;

  localparam logic [2:0] MID_UPPER_BANK = 3'b001;

  function automatic logic [STB_N-1:0] decode_fields(input logic [BYTE_W-1:0] b);
    logic [STB_N-1:0] s;
    s = '0;
    case (b[5:3])
      3'b010:  s[STB_EXT_CLR]  = 1'b1;
      3'b011:  s[STB_ABORT]    = 1'b1;
      3'b100:  s[STB_RX_ARM]   = 1'b1;
      3'b101:  s[STB_TXIP_CLR] = 1'b1;
      3'b110:  s[STB_ERR_CLR]  = 1'b1;
      3'b111:  s[STB_IUS_CLR]  = 1'b1;
      default: ;
    endcase
    case (b[7:6])
      2'b01:   s[STB_RXCRC_RST] = 1'b1;
      2'b10:   s[STB_TXCRC_RST] = 1'b1;
      2'b11:   s[STB_UNDR_CLR]  = 1'b1;
      default: ;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/ctrl_cmd_decoder.sv
module ctrl_cmd_decoder
  import ctrl_fe_pkg::*;
(
  input  logic                en,
  input  logic                alt,
  input  logic [BYTE_W-1:0]   cmd_byte,
  output logic [STB_N-1:0]    stb,
  output logic                ptr_load,
  output logic [PTR_W-1:0]    ptr_new,
  output logic                shift_load,
  output logic [SHIFT_W-1:0]  shift_code
);
  always_comb begin
    stb        = en ? decode_fields(cmd_byte) : '0;
    ptr_load   = en & ~alt;
    ptr_new    = {(cmd_byte[5:3] == MID_UPPER_BANK), cmd_byte[2:0]};
    shift_load = en & alt & cmd_byte[1];
    shift_code = cmd_byte[1:0];
  end
endmodule

// File: rtl/ctrl_ptr_ctrl.sv
module ctrl_ptr_ctrl
  import ctrl_fe_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc,
  input  logic               ptr_load,
  input  logic [PTR_W-1:0]   ptr_new,
  input  logic               shift_load,
  input  logic [SHIFT_W-1:0] shift_code,
  output logic [PTR_W-1:0]   ptr_q,
  output logic [SHIFT_W-1:0] shift_q
);
  logic [PTR_W-1:0]   ptr_d;
  logic [SHIFT_W-1:0] shift_d;
  logic               ptr_en;

  always_comb begin
    ptr_en = acc;
    ptr_d  = ptr_q;
    if (ptr_q != '0)   ptr_d = '0;
    else if (ptr_load) ptr_d = ptr_new;
    shift_d = shift_load ? shift_code : shift_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      shift_q <= '0;
    end else begin
      if (ptr_en)     ptr_q   <= ptr_d;
      if (shift_load) shift_q <= shift_d;
    end
  end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import ctrl_fe_pkg::*;
#(
  parameter int N_REG = NREG,
  parameter int W     = BYTE_W,
  localparam int IW   = $clog2(N_REG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IW-1:0]    idx,
  input  logic [W-1:0]     din,
  output logic [N_REG*W-1:0] regs_flat
);
  assign regs_flat[W-1:0] = '0;

  for (genvar i = 1; i < N_REG; i++) begin : g_reg
    logic         en_i;
    logic [W-1:0] q_i;
    assign en_i = we && (idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_i <= '0;
      else if (en_i) q_i <= din;
    end
    assign regs_flat[i*W +: W] = q_i;
  end
endmodule

// File: rtl/ctrl_reg_frontend.sv
module ctrl_reg_frontend
  import ctrl_fe_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs,
  input  logic                  rd,
  input  logic                  wr,
  input  logic                  alt_mode,
  input  logic [BUS_W-1:0]      wdata,
  output logic [BUS_W-1:0]      rdata,
  output logic [STB_N-1:0]      cmd_stb_o,
  output logic [SHIFT_W-1:0]    shift_o,
  output logic [NREG*BYTE_W-1:0] wreg_o
);
  logic               acc, wr_acc, rd_acc, at_zero;
  logic [PTR_W-1:0]   ptr_q, ptr_new;
  logic               ptr_load, shift_load;
  logic [SHIFT_W-1:0] shift_code;
  logic [BYTE_W-1:0]  lo_byte, rd_byte;
  logic [BYTE_W-1:0]  hi_lane_unused;

  assign acc            = cs & (rd ^ wr);
  assign wr_acc         = acc & wr;
  assign rd_acc         = acc & rd;
  assign at_zero        = (ptr_q == '0);
  assign lo_byte        = wdata[BYTE_W-1:0];
  assign hi_lane_unused = wdata[BUS_W-1:BYTE_W];

  ctrl_cmd_decoder u_dec (
    .en         (wr_acc & at_zero),
    .alt        (alt_mode),
    .cmd_byte   (lo_byte),
    .stb        (cmd_stb_o),
    .ptr_load   (ptr_load),
    .ptr_new    (ptr_new),
    .shift_load (shift_load),
    .shift_code (shift_code)
  );

  ctrl_ptr_ctrl u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .ptr_load   (ptr_load),
    .ptr_new    (ptr_new),
    .shift_load (shift_load),
    .shift_code (shift_code),
    .ptr_q      (ptr_q),
    .shift_q    (shift_o)
  );

  ctrl_reg_bank #(.N_REG(NREG), .W(BYTE_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (wr_acc & ~at_zero),
    .idx       (ptr_q),
    .din       (lo_byte),
    .regs_flat (wreg_o)
  );

  always_comb begin
    if (at_zero) rd_byte = {{(BYTE_W-SHIFT_W){1'b0}}, shift_o};
    else         rd_byte = wreg_o[ptr_q*BYTE_W +: BYTE_W];
    rdata = rd_acc ? {rd_byte, rd_byte} : '0;
  end
endmodule

// File: rtl/ctrl_fe_chk.sv
module ctrl_fe_chk
  import ctrl_fe_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs,
  input logic                   rd,
  input logic                   wr,
  input logic [PTR_W-1:0]       ptr,
  input logic [STB_N-1:0]       stb,
  input logic [BUS_W-1:0]       rdata,
  input logic [NREG*BYTE_W-1:0] wreg
);
  // R7
  ptr_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && (rd ^ wr) && ptr != '0) |=> (ptr == '0));

  // R4
  mid_field_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stb[5:0]) <= 1);

  // R5
  hi_field_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb[8:6]));

  // R10
  stb_only_on_ptr0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && wr && !rd && ptr == '0) |-> (stb == '0));

  // R8
  lane_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[BUS_W-1:BYTE_W] == rdata[BYTE_W-1:0]);

  // R11
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && wr && !rd) |=> $stable(wreg));
endmodule

bind ctrl_reg_frontend ctrl_fe_chk chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .cs    (cs),
  .rd    (rd),
  .wr    (wr),
  .ptr   (ptr_q),
  .stb   (cmd_stb_o),
  .rdata (rdata),
  .wreg  (wreg_o)
);

// File: tb/ctrl_reg_frontend_tb.sv
module ctrl_reg_frontend_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 28;
  localparam logic [1:0] OW = 2'd0;
  localparam logic [1:0] OR = 2'd1;

  // {req[47:44], op[43:42], alt[41], data[40:25], stb[24:16], rd[15:0]}
  localparam logic [47:0] VEC [NV] = '{
    {4'd2,  OW, 1'b0, 16'hFF05, 9'h000, 16'h0000}, // R2 ptr->5, upper lane junk
    {4'd6,  OW, 1'b0, 16'hAB3C, 9'h000, 16'h0000}, // R6 store 3C, no decode
    {4'd8,  OR, 1'b0, 16'h0000, 9'h000, 16'h0000}, // R8
    {4'd3,  OW, 1'b0, 16'h000D, 9'h000, 16'h0000}, // R3 ptr->13
    {4'd6,  OW, 1'b0, 16'h005A, 9'h000, 16'h0000},
    {4'd2,  OW, 1'b0, 16'h0005, 9'h000, 16'h0000},
    {4'd7,  OR, 1'b0, 16'h0000, 9'h000, 16'h3C3C}, // R7
    {4'd3,  OW, 1'b0, 16'h000D, 9'h000, 16'h0000},
    {4'd7,  OR, 1'b0, 16'h0000, 9'h000, 16'h5A5A},
    {4'd4,  OW, 1'b0, 16'h0010, 9'h001, 16'h0000}, // R4
    {4'd4,  OW, 1'b0, 16'h0018, 9'h002, 16'h0000},
    {4'd4,  OW, 1'b0, 16'h0020, 9'h004, 16'h0000},
    {4'd4,  OW, 1'b0, 16'h0028, 9'h008, 16'h0000},
    {4'd4,  OW, 1'b0, 16'h0030, 9'h010, 16'h0000},
    {4'd4,  OW, 1'b0, 16'h0038, 9'h020, 16'h0000},
    {4'd5,  OW, 1'b0, 16'h0040, 9'h040, 16'h0000}, // R5
    {4'd5,  OW, 1'b0, 16'h0080, 9'h080, 16'h0000},
    {4'd5,  OW, 1'b0, 16'h00C0, 9'h100, 16'h0000},
    {4'd4,  OW, 1'b0, 16'h00FF, 9'h120, 16'h0000}, // both fields, ptr->7
    {4'd7,  OR, 1'b0, 16'h0000, 9'h000, 16'h0000},
    {4'd9,  OW, 1'b1, 16'h0002, 9'h000, 16'h0000}, // R9 left
    {4'd8,  OR, 1'b1, 16'h0000, 9'h000, 16'h0202},
    {4'd9,  OW, 1'b1, 16'h000B, 9'h000, 16'h0000}, // right, 001 null
    {4'd9,  OR, 1'b1, 16'h0000, 9'h000, 16'h0303},
    {4'd9,  OW, 1'b1, 16'h0001, 9'h000, 16'h0000}, // code 01 keeps
    {4'd9,  OR, 1'b1, 16'h0000, 9'h000, 16'h0303},
    {4'd9,  OW, 1'b1, 16'h0012, 9'h001, 16'h0000},
    {4'd9,  OR, 1'b1, 16'h0000, 9'h000, 16'h0202}
  };

  logic clk = 1'b0;
  logic rst_n, cs, rd, wr, alt_mode;
  logic [15:0]  wdata, rdata;
  logic [8:0]   cmd_stb_o;
  logic [1:0]   shift_o;
  logic [127:0] wreg_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_reg_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .alt_mode(alt_mode),
    .wdata(wdata), .rdata(rdata), .cmd_stb_o(cmd_stb_o), .shift_o(shift_o),
    .wreg_o(wreg_o)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic r, input logic w, input logic a,
                       input logic [15:0] d);
    @(negedge clk);
    cs = c; rd = r; wr = w; alt_mode = a; wdata = d;
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cs = 0; rd = 0; wr = 0; alt_mode = 0; wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 regs", wreg_o, '0);
    check("R1 stb", {119'd0, cmd_stb_o}, '0);
    check("R1 shift", {126'd0, shift_o}, '0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[47:44], i);
      drive(1'b1, v[43:42] == OR, v[43:42] == OW, v[41], v[40:25]);
      check({tag, " stb"}, {119'd0, cmd_stb_o}, {119'd0, v[24:16]});
      if (v[43:42] == OR) check({tag, " rdata"}, {112'd0, rdata}, {112'd0, v[15:0]});
    end
    drive(1'b0, 0, 0, 0, 16'h0);
    // R6 R10: only registers 5 and 13 hold data; register 0 never stored
    check("R6 bank", wreg_o, (128'h5A << 104) | (128'h3C << 40));
    check("R8 idle rdata", {112'd0, rdata}, '0);

    // R1 reset mid-run
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R1 bank clr", wreg_o, '0);
    check("R1 shift clr", {126'd0, shift_o}, '0);
    @(negedge clk) rst_n = 1'b1;

    // R11: put 77 in register 6, then try ignored pointer writes
    drive(1, 0, 1, 0, 16'h0006);
    drive(1, 0, 1, 0, 16'h0077);
    drive(0, 0, 1, 0, 16'h0016);
    check("R11 cs low stb", {119'd0, cmd_stb_o}, '0);
    drive(1, 1, 1, 0, 16'h0016);
    check("R11 rd+wr stb", {119'd0, cmd_stb_o}, '0);
    check("R11 rd+wr rdata", {112'd0, rdata}, '0);
    drive(1, 1, 0, 0, 16'h0);
    check("R11 ptr unchanged", {112'd0, rdata}, '0);
    // R10: pointer write with command does not touch bank
    drive(1, 0, 1, 0, 16'h0036);
    check("R10 stb", {119'd0, cmd_stb_o}, 128'h010);
    drive(1, 1, 0, 0, 16'h0);
    check("R7 reg6 read", {112'd0, rdata}, 128'h7777);
    drive(0, 0, 0, 0, 16'h0);
    check("R10 bank", wreg_o, 128'h77 << 48);

    done = 1;
    finish_run();
  end
endmodule